// File: doc/BRIEF.md
# Periodic / one-shot countdown timer

This block is a programmable down-counter that runs in one of three states: off, periodic and one-shot. A single command port carries one operation per clock. The operations write the reload limit, with or without copying it into the count. They also write the count, start the timer in either running mode, stop it, and set the tick period. The period is set either as a whole number of clock cycles or as a whole number plus a 32-bit binary fraction. The live count is always visible on an output.

A tick generator divides the clock so that the count drops by one every period. When the count reaches zero the block raises a one-clock expiry pulse. In periodic mode it then reloads from the limit; in one-shot mode it stops. Any command that changes the count or the period while the timer runs restarts the tick timing from that command. A zero limit or a zero period turns the timer off instead of letting it run.

Top module: `downtick_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears to run state off, count 0, limit 0 and period 0, and `expire` is low after that edge.
- R2: `run_state` reads 0 when off, 1 when periodic and 2 when one-shot. A command is applied at the clock edge where `cmd_valid` is high. `cmd_op` takes the following codes: 0 writes the limit only; 1 writes the limit and reloads the count; 2 writes the count; 3 starts periodic; 4 starts one-shot; 5 stops; 6 sets an integer period from `cmd_data`; 7 sets the period from `cmd_data` plus the fraction `cmd_frac`.
- R3: In periodic mode with integer period P and count D, started at edge A, the count falls by one every P edges. `expire` is high for exactly the cycle after edge A+D*P. The count then reloads to limit L, and the next expiry comes L*P edges later.
- R4: In one-shot mode the expiry happens on the same schedule. After it, `run_state` is 0 and the count is 0, and no further expiry occurs.
- R5: With fraction F, the first N ticks after a (re)start take N*P + floor(N*F/2^32) cycles. The fraction phase restarts at every start, reload and re-arm, so each expiry interval is D*P + floor(D*F/2^32). Command 6 clears the fraction to 0.
- R6: A start command while the timer is running is ignored: mode and timing are unchanged. A start while the integer period is 0 is refused: the timer stays off, the count is unchanged and there is no expiry.
- R7: Arming with a count of 0 pulses `expire` at once and loads the count from the limit. Arming includes a start, a running write or a periodic reload. If the resulting count is 0, or the integer period is 0, the timer goes off and keeps that count.
- R8: A stop command turns the timer off and keeps the live count. The partial tick already elapsed is lost, so a later start waits a full D*P cycles.
- R9: Command 0 changes only the limit. The count and the running timing are unchanged, and the new limit is used at the next reload. Command 1 also sets the count to the new limit. If the timer is running, command 1 restarts timing from that edge.
- R10: While running, commands 2, 6 and 7 re-arm from their edge, with the written count or the current count respectively. While off, they only store their value.
- R11: `count_out` shows the stored count while off. While running, k edges after the arm edge it shows D - floor(k/P) for k < D*P and never shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Apply `cmd_op` at this edge |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_data | input | CW | Limit, count or integer period value |
| cmd_frac | input | FW | Period fraction for operation 7 |
| count_out | output | CW | Live count |
| run_state | output | 2 | 0 off, 1 periodic, 2 one-shot |
| expire | output | 1 | One-cycle expiry pulse |

## Verification
The bench sweeps small periods and counts and checks the count on every cycle of a run. A design that decremented one cycle early or late would show a wrong value at a tick boundary. Fractions are swept against the floor formula, which exposes a phase that is not restarted per interval or a carry dropped by one position. The corner cases covered are start with a zero count or a zero limit, a zero period at start and while running, and a start issued while already running. They also cover a stop in the middle of a tick, a limit write without reload, and count or period writes while running. Each of these would show as a misplaced or missing expiry, a timer left running, or a count that moved when it should have held.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  typedef enum logic [1:0] {
    RUN_OFF      = 2'd0,
    RUN_PERIODIC = 2'd1,
    RUN_ONESHOT  = 2'd2
  } run_mode_e;

  typedef enum logic [2:0] {
    OP_LIMIT       = 3'd0,
    OP_LIMIT_LOAD  = 3'd1,
    OP_COUNT       = 3'd2,
    OP_GO_PERIODIC = 3'd3,
    OP_GO_ONESHOT  = 3'd4,
    OP_HALT        = 3'd5,
    OP_PERIOD      = 3'd6,
    OP_PERIOD_FRAC = 3'd7
  } cmd_op_e;
endpackage

// File: rtl/dtm_tick_gen.sv
module dtm_tick_gen #(
  parameter int PW = 32,
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          restart,
  input  logic [PW-1:0] per_int,
  input  logic [FW-1:0] per_frac,
  output logic          tick
);
  localparam int RW = PW + 1;

  logic [RW-1:0] remain;
  logic [FW-1:0] phase;
  logic [FW:0]   sum;
  logic [RW-1:0] next_len;

  // The phase starts from zero on every restart; a carry stretches a tick by one cycle.
  always_comb begin
    sum      = (restart ? {1'b0, {FW{1'b0}}} : {1'b0, phase}) + {1'b0, per_frac};
    next_len = {1'b0, per_int} + {{PW{1'b0}}, sum[FW]};
  end

  assign tick = active && (remain == RW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      phase  <= '0;
    end else if (restart || tick) begin
      remain <= next_len;
      phase  <= sum[FW-1:0];
    end else if (active && remain != '0) begin
      remain <= remain - RW'(1);
    end
  end
endmodule

// File: rtl/dtm_ctrl.sv
module dtm_ctrl
  import dtm_pkg::*;
#(
  parameter int CW = 32,
  parameter int PW = 32,
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [CW-1:0] cmd_data,
  input  logic [FW-1:0] cmd_frac,
  input  logic          tick,
  output run_mode_e     mode_q,
  output logic [CW-1:0] count_q,
  output logic [PW-1:0] pint_q,
  output logic [PW-1:0] n_pint,
  output logic [FW-1:0] n_pfrac,
  output logic          restart,
  output logic          expire_q
);
  cmd_op_e       op;
  run_mode_e     n_mode, arm_mode;
  logic [CW-1:0] n_count, n_limit, arm_val, load_val, limit_q;
  logic [FW-1:0] pfrac_q;
  logic          fire, arm;

  assign op = cmd_op_e'(cmd_op);

  always_comb begin
    n_mode   = mode_q;
    n_count  = count_q;
    n_limit  = limit_q;
    n_pint   = pint_q;
    n_pfrac  = pfrac_q;
    fire     = 1'b0;
    arm      = 1'b0;
    arm_val  = count_q;
    arm_mode = mode_q;
    restart  = 1'b0;
    // Tick from the generator: decrement, or expire.
    if (mode_q != RUN_OFF && tick) begin
      if (count_q > CW'(1)) begin
        n_count = count_q - CW'(1);
      end else begin
        fire    = 1'b1;
        n_count = '0;
        if (mode_q == RUN_ONESHOT) begin
          n_mode = RUN_OFF;
        end else begin
          arm     = 1'b1;
          arm_val = '0;
        end
      end
    end
    // Commands act on the state as left by a coincident tick.
    if (cmd_valid) begin
      case (op)
        OP_LIMIT: n_limit = cmd_data;
        OP_LIMIT_LOAD: begin
          n_limit = cmd_data;
          if (n_mode == RUN_OFF) begin
            n_count = cmd_data;
          end else begin
            arm      = 1'b1;
            arm_val  = cmd_data;
            arm_mode = n_mode;
          end
        end
        OP_COUNT: begin
          if (n_mode == RUN_OFF) begin
            n_count = cmd_data;
          end else begin
            arm      = 1'b1;
            arm_val  = cmd_data;
            arm_mode = n_mode;
          end
        end
        OP_GO_PERIODIC, OP_GO_ONESHOT: begin
          if (mode_q == RUN_OFF && pint_q != '0) begin
            arm      = 1'b1;
            arm_val  = count_q;
            arm_mode = (op == OP_GO_ONESHOT) ? RUN_ONESHOT : RUN_PERIODIC;
          end
        end
        OP_HALT: begin
          n_mode = RUN_OFF;
          arm    = 1'b0;
        end
        default: begin
          n_pint  = PW'(cmd_data);
          n_pfrac = (op == OP_PERIOD_FRAC) ? cmd_frac : '0;
          if (n_mode != RUN_OFF) begin
            arm      = 1'b1;
            arm_val  = n_count;
            arm_mode = n_mode;
          end
        end
      endcase
    end
    // Arming: zero count fires and takes the limit; zero count or period shuts off.
    load_val = arm_val;
    if (arm) begin
      if (arm_val == '0) begin
        fire     = 1'b1;
        load_val = n_limit;
      end
      n_count = load_val;
      if (load_val == '0 || n_pint == '0) begin
        n_mode = RUN_OFF;
      end else begin
        n_mode  = arm_mode;
        restart = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= RUN_OFF;
      count_q  <= '0;
      limit_q  <= '0;
      pint_q   <= '0;
      pfrac_q  <= '0;
      expire_q <= 1'b0;
    end else begin
      mode_q   <= n_mode;
      count_q  <= n_count;
      limit_q  <= n_limit;
      pint_q   <= n_pint;
      pfrac_q  <= n_pfrac;
      expire_q <= fire;
    end
  end
endmodule

// File: rtl/downtick_timer.sv
module downtick_timer
  import dtm_pkg::*;
#(
  parameter int CW = 32,
  parameter int PW = 32,
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [CW-1:0] cmd_data,
  input  logic [FW-1:0] cmd_frac,
  output logic [CW-1:0] count_out,
  output logic [1:0]    run_state,
  output logic          expire
);
  run_mode_e     mode_q;
  logic [CW-1:0] count_q;
  logic [PW-1:0] per_int_q, n_pint;
  logic [FW-1:0] n_pfrac;
  logic          restart, tick_pulse, expire_q;

  dtm_ctrl #(.CW(CW), .PW(PW), .FW(FW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .cmd_frac  (cmd_frac),
    .tick      (tick_pulse),
    .mode_q    (mode_q),
    .count_q   (count_q),
    .pint_q    (per_int_q),
    .n_pint    (n_pint),
    .n_pfrac   (n_pfrac),
    .restart   (restart),
    .expire_q  (expire_q)
  );

  dtm_tick_gen #(.PW(PW), .FW(FW)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .active   (mode_q != RUN_OFF),
    .restart  (restart),
    .per_int  (n_pint),
    .per_frac (n_pfrac),
    .tick     (tick_pulse)
  );

  assign count_out = count_q;
  assign run_state = mode_q;
  assign expire    = expire_q;
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker #(
  parameter int CW = 32,
  parameter int PW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic [CW-1:0] count_out,
  input logic [1:0]    run_state,
  input logic          expire,
  input logic          tick,
  input logic [PW-1:0] per_int
);
  logic is_start;
  assign is_start = cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4);

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (run_state != 2'd0 && is_start && !tick) |=> run_state == $past(run_state)); // R6

  AST_ZERO_PERIOD_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (run_state == 2'd0 && is_start && per_int == '0) |=> (run_state == 2'd0 && !expire)); // R6

  AST_HALT_OFF: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd5) |=> run_state == 2'd0); // R8

  AST_LIMIT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (run_state == 2'd0 && cmd_valid && cmd_op == 3'd0) |=> ($stable(count_out) && run_state == 2'd0)); // R9

  AST_ONESHOT_DONE: assert property (@(posedge clk) disable iff (rst)
    ($past(run_state) == 2'd2 && expire && !$past(cmd_valid)) |-> (run_state == 2'd0 && count_out == '0)); // R4

  AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (run_state != 2'd0) |-> (count_out != '0 && per_int != '0)); // R7

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    run_state != 2'd3); // R2
endmodule

bind downtick_timer dtm_checker #(.CW(CW), .PW(PW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .count_out (count_out),
  .run_state (run_state),
  .expire    (expire),
  .tick      (tick_pulse),
  .per_int   (per_int_q)
);

// File: tb/downtick_timer_test.sv
module downtick_timer_test;
  localparam int CW = 32;
  localparam int PW = 32;
  localparam int FW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [CW-1:0] cmd_data = '0;
  logic [FW-1:0] cmd_frac = '0;
  logic [CW-1:0] count_out;
  logic [1:0]    run_state;
  logic          expire;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  downtick_timer #(.CW(CW), .PW(PW), .FW(FW)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_frac(cmd_frac),
    .count_out(count_out), .run_state(run_state), .expire(expire)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input int op, input longint data, input longint frac);
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_data  = CW'(data);
    cmd_frac  = FW'(frac);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic measure(output int k, input int maxk);
    k = 0;
    while (!expire && k < maxk) begin
      @(negedge clk);
      k++;
    end
    if (!expire) k = -1;
  endtask

  task automatic idle_no_expire(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (expire) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic setup(input int p, input longint f, input longint lim, input longint cnt);
    issue(5, 0, 0);
    if (f != 0) issue(7, p, f); else issue(6, p, 0);
    issue(0, lim, 0);
    issue(2, cnt, 0);
  endtask

  initial begin
    int k;
    longint ex;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(run_state == 2'd0, "R1 state", run_state, 0);
    chk(count_out == 0, "R1 count", count_out, 0);
    chk(expire == 1'b0, "R1 expire", expire, 0);

    // R3 / R11 periodic sweep with per-cycle count checks
    for (int p = 1; p <= 3; p++) begin
      for (int d = 1; d <= 3; d++) begin
        setup(p, 0, d + 1, d);
        issue(3, 0, 0);
        chk(run_state == 2'd1, "R2 periodic state", run_state, 1);
        for (int kk = 0; kk < d * p; kk++) begin
          chk(count_out == CW'(d - kk / p), "R11 live count", count_out, d - kk / p);
          chk(expire == 1'b0, "R3 early expire", expire, 0);
          @(negedge clk);
        end
        chk(expire == 1'b1, "R3 expiry time", expire, 1);
        chk(count_out == CW'(d + 1), "R3 reload", count_out, d + 1);
        @(negedge clk);
        chk(expire == 1'b0, "R3 single pulse", expire, 0);
        measure(k, 1000);
        chk(k == (d + 1) * p - 1, "R3 second period", k, (d + 1) * p - 1);
      end
    end

    // R4 one-shot sweep
    for (int p = 1; p <= 3; p++) begin
      for (int d = 1; d <= 3; d++) begin
        setup(p, 0, 4, d);
        issue(4, 0, 0);
        chk(run_state == 2'd2, "R2 oneshot state", run_state, 2);
        measure(k, 1000);
        chk(k == d * p, "R4 oneshot expiry", k, d * p);
        chk(run_state == 2'd0, "R4 oneshot off", run_state, 0);
        chk(count_out == 0, "R4 oneshot count", count_out, 0);
        idle_no_expire(8, "R4 no repeat");
      end
    end

    // R5 fractional periods
    for (int p = 1; p <= 3; p++) begin
      for (int fi = 0; fi < 4; fi++) begin
        for (int di = 0; di < 3; di++) begin
          longint f;
          int d;
          f = (fi == 0) ? 64'h4000_0000 : (fi == 1) ? 64'h8000_0000 :
              (fi == 2) ? 64'hC000_0000 : 64'h1234_5678;
          d = (di == 0) ? 1 : (di == 1) ? 3 : 7;
          setup(p, f, 5, d);
          issue(3, 0, 0);
          measure(k, 1000);
          ex = longint'(d) * p + ((longint'(d) * f) >> 32);
          chk(k == ex, "R5 first interval", k, ex);
          @(negedge clk);
          measure(k, 1000);
          ex = 5 * p + ((5 * f) >> 32) - 1;
          chk(k == ex, "R5 reload interval", k, ex);
        end
      end
    end
    // R5 integer period write clears fraction
    issue(5, 0, 0);
    issue(7, 2, 64'h8000_0000);
    issue(6, 2, 0);
    issue(2, 3, 0);
    issue(4, 0, 0);
    measure(k, 1000);
    chk(k == 6, "R5 fraction cleared", k, 6);

    // R6 start while running ignored
    setup(2, 0, 3, 3);
    issue(3, 0, 0);
    repeat (2) @(negedge clk);
    issue(4, 0, 0);
    chk(run_state == 2'd1, "R6 start ignored state", run_state, 1);
    measure(k, 1000);
    chk(k == 3, "R6 start ignored timing", k, 3);
    chk(run_state == 2'd1, "R6 still periodic", run_state, 1);
    // R6 zero period start refused
    setup(0, 0, 4, 4);
    issue(3, 0, 0);
    chk(run_state == 2'd0, "R6 zero period state", run_state, 0);
    chk(count_out == 4, "R6 zero period count", count_out, 4);
    chk(expire == 1'b0, "R6 zero period expire", expire, 0);
    idle_no_expire(5, "R6 zero period quiet");

    // R7 start with zero count fires and reloads
    setup(1, 0, 4, 0);
    issue(3, 0, 0);
    chk(expire == 1'b1, "R7 immediate expire", expire, 1);
    chk(count_out == 4, "R7 load limit", count_out, 4);
    chk(run_state == 2'd1, "R7 running", run_state, 1);
    @(negedge clk);
    measure(k, 1000);
    chk(k == 3, "R7 period after load", k, 3);
    // R7 zero count and zero limit
    setup(1, 0, 0, 0);
    issue(3, 0, 0);
    chk(expire == 1'b1, "R7 zero limit expire", expire, 1);
    chk(run_state == 2'd0, "R7 zero limit off", run_state, 0);
    // R7 periodic reload with zero limit
    setup(1, 0, 0, 2);
    issue(3, 0, 0);
    measure(k, 1000);
    chk(k == 2, "R7 expiry before zero reload", k, 2);
    chk(run_state == 2'd0, "R7 zero reload off", run_state, 0);
    chk(count_out == 0, "R7 zero reload count", count_out, 0);
    // R7 zero period while running
    setup(3, 0, 5, 5);
    issue(3, 0, 0);
    issue(6, 0, 0);
    chk(run_state == 2'd0, "R7 zero period running off", run_state, 0);
    chk(count_out == 5, "R7 zero period keeps count", count_out, 5);
    idle_no_expire(6, "R7 zero period quiet");

    // R8 stop mid tick
    setup(4, 0, 5, 5);
    issue(3, 0, 0);
    repeat (6) @(negedge clk);
    issue(5, 0, 0);
    chk(run_state == 2'd0, "R8 stop state", run_state, 0);
    chk(count_out == 4, "R8 stop count", count_out, 4);
    idle_no_expire(10, "R8 stopped quiet");
    chk(count_out == 4, "R8 count held", count_out, 4);
    issue(3, 0, 0);
    measure(k, 1000);
    chk(k == 16, "R8 partial tick lost", k, 16);

    // R9 limit write without reload while running
    setup(3, 0, 4, 4);
    issue(3, 0, 0);
    @(negedge clk);
    issue(0, 2, 0);
    chk(count_out == 4, "R9 count unchanged", count_out, 4);
    measure(k, 1000);
    chk(k == 10, "R9 timing unchanged", k, 10);
    @(negedge clk);
    measure(k, 1000);
    chk(k == 5, "R9 new limit used", k, 5);
    issue(1, 5, 0);
    chk(count_out == 5, "R9 reload count", count_out, 5);
    measure(k, 1000);
    chk(k == 15, "R9 reload rearm", k, 15);
    issue(5, 0, 0);
    issue(1, 7, 0);
    chk(count_out == 7 && run_state == 2'd0, "R9 reload while off", count_out, 7);

    // R10 count write while running re-arms
    setup(2, 0, 6, 6);
    issue(3, 0, 0);
    repeat (3) @(negedge clk);
    issue(2, 2, 0);
    chk(count_out == 2, "R10 count written", count_out, 2);
    measure(k, 1000);
    chk(k == 4, "R10 count rearm", k, 4);
    @(negedge clk);
    issue(2, 0, 0);
    chk(expire == 1'b1, "R10 zero count write expires", expire, 1);
    chk(count_out == 6, "R10 zero count loads limit", count_out, 6);
    // R10 period change while running
    setup(4, 0, 3, 3);
    issue(3, 0, 0);
    repeat (5) @(negedge clk);
    issue(6, 2, 0);
    chk(count_out == 2, "R10 period keeps count", count_out, 2);
    measure(k, 1000);
    chk(k == 4, "R10 period rearm", k, 4);
    // R10 count write while off only stores
    issue(5, 0, 0);
    issue(2, 9, 0);
    chk(count_out == 9 && run_state == 2'd0, "R10 store while off", count_out, 9);
    idle_no_expire(4, "R10 off quiet");
    chk(count_out == 9, "R11 stored count read", count_out, 9);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule